// File: doc/BRIEF.md
# Shared-Stage Four-Phase Call with Built-In Arbitration

This block lets several four-phase handshake clients share one downstream stage. Each client raises its own request line. The block merges the granted client's request onto a single shared request. It steers the shared stage's acknowledge, both its rise and its fall, back to whichever client owns the current handshake. Everything is modelled as logic sampled on a clock, and all request and acknowledge levels are seen as sampled values.

A bare merge of requests goes wrong in one case. If a second client raises its request while the first client's handshake is still returning to zero, the acknowledge can be routed to the wrong client and the handshake can lock up. To prevent this, the block keeps one owner register. A new client is accepted only when no owner is held. An owner is released only after both its request and the shared acknowledge have returned low. When several requests wait at once, they are served in round-robin order.

The one-hot owner vector is exported, so that a datapath multiplexer can pick the granted client's data. The number of clients is a parameter, from 2 up to 16.

Top module: `handshake_call_arb`

## Requirements
- R1: While reset is held, and immediately after it, `owner_sel`, `shr_req` and every bit of `cli_ack` are 0.
- R2: If no owner is held at a clock edge and at least one `cli_req` bit is high, then after that edge `owner_sel` has exactly one bit set, and that bit is a client whose request was high at the edge.
- R3: `shr_req` follows the level of the owning client's request, passing both its rise and its fall. It is 0 whenever `owner_sel` is 0.
- R4: `cli_ack[i]` follows `shr_ack`, both edges, only while client i is the owner. Every other bit of `cli_ack` stays 0.
- R5: An owner is kept across every edge at which its request or `shr_ack` is high. It is cleared at the first edge at which both are low. A new grant can be made no earlier than the edge after that.
- R6: A request from a client that is not the owner reaches neither `shr_req` nor its own `cli_ack`. This holds even when it rises while the owner's handshake is returning to zero.
- R7: When a grant is made, the winner is the first requesting client found in increasing index order after the client granted last, wrapping from the highest index to index 0. After reset, the last-granted client is taken to be index N_CLI-1, so index 0 wins the first contest.
- R8: `owner_sel` and `cli_ack` each have at most one bit set at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cli_req | input | N_CLI | Four-phase request from each client |
| cli_ack | output | N_CLI | Acknowledge routed back to each client |
| shr_req | output | 1 | Merged request to the shared stage |
| shr_ack | input | 1 | Acknowledge from the shared stage |
| owner_sel | output | N_CLI | One-hot owner of the current handshake, for a data multiplexer |

## Verification
A three-client instance is tested in two ways.

The first is a directed, well-formed handshake in which client 1 raises its request just as client 0 starts returning to zero. This separates correct hold-off from the misrouting fault: `cli_ack[1]` must stay low and `shr_req` must follow only client 0.

The second is a sweep of every three-cycle run over all sixteen combinations of request and acknowledge levels. It drives the block through simultaneous contests, release with a waiting request, and an acknowledge that stays high. Each cycle is compared with an arithmetic reference for the owner, the round-robin pointer and the routing. This tells apart a wrong winner, an early or late release, and a leak of a non-owner's request.

// File: rtl/call_arb_pkg.sv
package call_arb_pkg;

  localparam int MAX_CLI = 16;

  // Round-robin pick: first requester after the one-hot 'last', wrapping at n.
  function automatic logic [MAX_CLI-1:0] rr_pick(
    input logic [MAX_CLI-1:0] req,
    input logic [MAX_CLI-1:0] last,
    input int                 n
  );
    int                 base;
    int                 j;
    logic               found;
    logic [MAX_CLI-1:0] g;
    base  = 0;
    for (int i = 0; i < MAX_CLI; i++) begin
      if (i < n && last[i[3:0]]) base = i;
    end
    g     = '0;
    found = 1'b0;
    for (int k = 1; k <= MAX_CLI; k++) begin
      if (k <= n) begin
        j = base + k;
        if (j >= n) j = j - n;
        if (!found && req[j[3:0]]) begin
          g[j[3:0]] = 1'b1;
          found     = 1'b1;
        end
      end
    end
    return g;
  endfunction

endpackage

// File: rtl/call_arb_pick.sv
module call_arb_pick
  import call_arb_pkg::*;
#(
  parameter int N_CLI = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CLI-1:0] req,
  input  logic [N_CLI-1:0] last,
  output logic [N_CLI-1:0] grant
);

  logic [MAX_CLI-1:0] req_w;
  logic [MAX_CLI-1:0] last_w;
  logic [MAX_CLI-1:0] grant_w;

  always_comb begin
    req_w   = MAX_CLI'(req);
    last_w  = MAX_CLI'(last);
    grant_w = rr_pick(req_w, last_w, N_CLI);
    grant   = grant_w[N_CLI-1:0];
  end

  // R7: a pending contest yields one winner drawn from the requesters
  p_pick_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ($onehot(grant) && ((grant & ~req) == '0)));

endmodule

// File: rtl/call_arb_owner.sv
module call_arb_owner #(
  parameter int N_CLI = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CLI-1:0] cli_req,
  input  logic             shr_ack,
  input  logic [N_CLI-1:0] grant,
  output logic [N_CLI-1:0] owner,
  output logic [N_CLI-1:0] last
);

  localparam logic [N_CLI-1:0] LAST_RST = N_CLI'(1) << (N_CLI - 1);

  logic idle;
  logic own_req;
  logic grant_ev;
  logic release_ev;

  assign idle       = (owner == '0);
  assign own_req    = |(owner & cli_req);
  assign grant_ev   = idle && (|cli_req);
  assign release_ev = !idle && !own_req && !shr_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner <= '0;
      last  <= LAST_RST;
    end else if (grant_ev) begin
      owner <= grant;
      last  <= grant;
    end else if (release_ev) begin
      owner <= '0;
    end
  end

  // R2: an idle edge with a request pending produces one owner that was requesting
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && (|cli_req)) |=> (($countones(owner) == 1) && (|(owner & $past(cli_req)))));

  // R5: owner is kept while its request or the shared acknowledge is high
  p_hold_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && (own_req || shr_ack)) |=> $stable(owner));

  // R5: owner is dropped once both have returned low
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !own_req && !shr_ack) |=> (owner == '0));

endmodule

// File: rtl/call_arb_route.sv
module call_arb_route #(
  parameter int N_CLI = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CLI-1:0] owner,
  input  logic [N_CLI-1:0] cli_req,
  input  logic             shr_ack,
  output logic             shr_req,
  output logic [N_CLI-1:0] cli_ack
);

  assign shr_req = |(owner & cli_req);

  for (genvar g = 0; g < N_CLI; g++) begin : g_ack
    assign cli_ack[g] = owner[g] & shr_ack;
  end

  // R3: nothing reaches the shared stage with no owner
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == '0) |-> (!shr_req && (cli_ack == '0)));

  // R4: a client acknowledge only appears with the shared acknowledge
  p_ack_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|cli_ack) |-> shr_ack);

  // R8: acknowledges never overlap
  p_ack_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cli_ack));

endmodule

// File: rtl/handshake_call_arb.sv
module handshake_call_arb #(
  parameter int N_CLI = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CLI-1:0] cli_req,
  output logic [N_CLI-1:0] cli_ack,
  output logic             shr_req,
  input  logic             shr_ack,
  output logic [N_CLI-1:0] owner_sel
);

  logic [N_CLI-1:0] grant;
  logic [N_CLI-1:0] owner;
  logic [N_CLI-1:0] last;

  call_arb_pick #(.N_CLI(N_CLI)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (cli_req),
    .last  (last),
    .grant (grant)
  );

  call_arb_owner #(.N_CLI(N_CLI)) u_owner (
    .clk     (clk),
    .rst_n   (rst_n),
    .cli_req (cli_req),
    .shr_ack (shr_ack),
    .grant   (grant),
    .owner   (owner),
    .last    (last)
  );

  call_arb_route #(.N_CLI(N_CLI)) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .owner   (owner),
    .cli_req (cli_req),
    .shr_ack (shr_ack),
    .shr_req (shr_req),
    .cli_ack (cli_ack)
  );

  assign owner_sel = owner;

  // R8: exported owner is one-hot or empty
  p_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner_sel));

  // R6: shared request is only raised by the owner's own request
  p_no_leak_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shr_req |-> (|(owner_sel & cli_req)));

endmodule

// File: tb/handshake_call_arb_bench.sv
module handshake_call_arb_bench;

  localparam int NC       = 3;
  localparam int T_CLK    = 10;
  localparam int WD_LIMIT = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] cli_req = '0;
  logic [NC-1:0] cli_ack;
  logic          shr_req;
  logic          shr_ack = 1'b0;
  logic [NC-1:0] owner_sel;

  int n_cmp  = 0;
  int n_bad  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // Reference state
  logic [NC-1:0] m_owner;
  int            m_last;

  always #(T_CLK/2) clk = ~clk;

  handshake_call_arb #(.N_CLI(NC)) u_handshake_call_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .cli_req   (cli_req),
    .cli_ack   (cli_ack),
    .shr_req   (shr_req),
    .shr_ack   (shr_ack),
    .owner_sel (owner_sel)
  );

  task automatic check(input string tag, input logic [NC-1:0] act, input logic [NC-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cycles, act, exp);
    end
  endtask

  function automatic int winner(input logic [NC-1:0] r, input int last_i);
    for (int k = 1; k <= NC; k++) begin
      if (r[(last_i + k) % NC]) return (last_i + k) % NC;
    end
    return -1;
  endfunction

  // Drive one cycle, compare outputs, then advance the reference at the edge
  task automatic step(input logic [NC-1:0] r, input logic a);
    int w;
    @(negedge clk);
    cli_req = r;
    shr_ack = a;
    #1;
    check("R2 R5 R7 owner_sel", owner_sel, m_owner);
    check("R3 R6 shr_req", NC'(shr_req), NC'(|(m_owner & r)));
    check("R4 R6 cli_ack", cli_ack, a ? m_owner : '0);
    check("R8 onehot", NC'($countones(owner_sel) <= 1 && $countones(cli_ack) <= 1), NC'(1));
    @(posedge clk);
    cycles++;
    if (m_owner == '0) begin
      w = winner(r, m_last);
      if (w >= 0) begin
        m_owner = NC'(1) << w;
        m_last  = w;
      end
    end else if (!(|(m_owner & r)) && !a) begin
      m_owner = '0;
    end
  endtask

  initial begin
    m_owner = '0;
    m_last  = NC - 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 owner_sel reset", owner_sel, '0);
    check("R1 shr_req reset", NC'(shr_req), '0);
    check("R1 cli_ack reset", cli_ack, '0);
    rst_n = 1'b1;
    #1;
    check("R1 shr_req after reset", NC'(shr_req), '0);

    // Directed: client 1 rises while client 0 returns to zero (R6)
    step(3'b001, 1'b0);
    step(3'b001, 1'b0);
    step(3'b001, 1'b1);
    step(3'b010, 1'b1);
    step(3'b010, 1'b1);
    step(3'b010, 1'b0);
    step(3'b010, 1'b0);
    step(3'b010, 1'b1);
    step(3'b000, 1'b1);
    step(3'b000, 1'b0);
    // Simultaneous contest after reset-time pointer moved (R7)
    step(3'b111, 1'b0);
    step(3'b111, 1'b0);
    step(3'b000, 1'b0);
    step(3'b111, 1'b0);
    step(3'b000, 1'b0);
    step(3'b000, 1'b0);

    // Sweep every three-cycle run of request/acknowledge levels
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 16; c++) begin
          step(NC'(a), a[3]);
          step(NC'(b), b[3]);
          step(NC'(c), c[3]);
        end
      end
    end
    step('0, 1'b0);
    step('0, 1'b0);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule